// File: doc/BRIEF.md
# Sign-Bit Programmable Preamble Correlator

This block sits at the front of an OFDM receiver and looks for a known time-domain preamble in the incoming complex sample stream. It keeps only the sign of the in-phase and quadrature parts of every sample. It compares a sliding window of those signs with a set of expected signs, called coefficients, that software loads at run time. A full-precision complex multiply-accumulate is replaced by one XNOR per bit and a population-count adder tree. The number of matching bits is published every cycle. When that number crosses a programmable threshold, a single-cycle detect pulse starts the downstream receive chain.

The coefficients arrive ready-made as sign bits through a word-wide write port. In the default staged configuration, writes land in a staging bank and reach the correlator only when a commit strobe is given. A whole new preamble therefore takes effect in one step, between two samples. Detection stays blocked after reset until the window holds a full set of real samples.

Top module: `sign_preamble_correlator`

## Requirements
- R1: Only the most significant bit (two's-complement sign, 1 = negative) of `smp_i` and `smp_q` affects the block; the magnitude bits have no effect on `match_count` or `detect`.
- R2: On each cycle with `smp_valid` high, the window shifts up by two bits and the new sample enters at the bottom: its I sign at bit 1 and its Q sign at bit 0. A sample received k samples before the newest therefore sits at bits 2k+1 (I) and 2k (Q). The two bits at the top drop out. Without `smp_valid` the window holds.
- R3: Each window bit scores 1 when it equals the coefficient bit at the same position (XNOR). `match_count` is the sum of all 2*WIN_SAMPLES scores. It is registered and shows the window and active coefficients of the previous cycle.
- R4: `match_count` lies in 0..2*WIN_SAMPLES (0..256 by default, 9 bits). It reaches the maximum when every window bit equals its coefficient bit.
- R5: A write with `coef_wr_en` puts `coef_wr_data` in staging word `coef_wr_addr`. Word w covers coefficient bits [32w+31:32w]. A staged write alone leaves `match_count` unchanged. `coef_commit` copies all staging words into the active coefficients on one edge. The copy takes the staging contents from before any write in that same cycle.
- R6: The count is above threshold only when `match_count` > `thresh`, strictly. A count equal to `thresh` does not qualify.
- R7: `detect` is a one-cycle pulse, aligned with the `match_count` value that first rises above threshold. A count that stays above threshold gives no further pulse. A new pulse needs the count to fall to or below `thresh` first.
- R8: `detect` stays low until WIN_SAMPLES valid samples have arrived since reset. If the count is already above threshold at that point, the first qualifying count gives one pulse.
- R9: During reset `match_count` and `detect` are 0. Reset also clears the window, the coefficients, the staging bank and the fill counter, so the first count after reset is 2*WIN_SAMPLES.
- R10: `match_count` keeps its value when no sample is accepted and no commit happens. A change of `thresh` alone does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A new complex sample is present this cycle |
| smp_i | input | SAMPLE_W (12) | In-phase sample, two's complement |
| smp_q | input | SAMPLE_W (12) | Quadrature sample, two's complement |
| coef_wr_en | input | 1 | Write one coefficient word into staging |
| coef_wr_addr | input | log2(2*WIN_SAMPLES/COEF_WORD_W) (3) | Staging word index |
| coef_wr_data | input | COEF_WORD_W (32) | Coefficient sign bits for that word |
| coef_commit | input | 1 | Copy staging bank into active coefficients |
| thresh | input | log2(2*WIN_SAMPLES+1) (9) | Detection threshold |
| match_count | output | log2(2*WIN_SAMPLES+1) (9) | Number of matching sign bits |
| detect | output | 1 | One-cycle preamble detection pulse |

## Verification
The bench runs a cycle-accurate arithmetic model that builds the window, the staging bank and the active coefficients from the stimulus. It checks the count and the pulse on every cycle. Stimulus patterns:
- Noise-like samples with varied magnitudes, to exercise the XNOR sum.
- Samples built to match the loaded preamble exactly. These separate correct window ordering and bit placement from near misses: only the right order gives a full-scale count.
- Extreme values (0, -1, largest, most negative), to show that only the sign bit counts.
- A threshold of zero while the window fills, to show the fill gate.
- A threshold equal to the count and then one below it, to tell a strict from an inclusive compare.
- A commit of the inverted preamble against a perfectly aligned window, so the count drops from full scale to zero in one step. A piecemeal update would show intermediate counts instead.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

   localparam int unsigned SIGN_PAIR_W = 2;

   typedef struct packed {
      logic i_sgn;
      logic q_sgn;
   } sign_pair_t;

   function automatic int unsigned count_width(input int unsigned nbits);
      return $clog2(nbits + 1);
   endfunction

endpackage

// File: rtl/cpc_window.sv
module cpc_window
   import cpc_pkg::*;
#(
   parameter int unsigned SAMPLE_W    = 12,
   parameter int unsigned WIN_SAMPLES = 128
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        smp_valid,
   input  logic                        i_sign,
   input  logic                        q_sign,
   output logic [2*WIN_SAMPLES-1:0]    window,
   output logic                        filled
);

   localparam int unsigned WIN_BITS = SIGN_PAIR_W * WIN_SAMPLES;
   localparam int unsigned FILL_W   = count_width(WIN_SAMPLES);
   localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(WIN_SAMPLES);

   sign_pair_t              incoming;
   logic [WIN_BITS-1:0]     win_q;
   logic [FILL_W-1:0]       fill_q;

   assign incoming = '{i_sgn: i_sign, q_sgn: q_sign};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q  <= '0;
         fill_q <= '0;
      end else if (smp_valid) begin
         win_q <= {win_q[WIN_BITS-SIGN_PAIR_W-1:0], incoming};
         if (fill_q != FILL_MAX) begin
            fill_q <= fill_q + 1'b1;
         end
      end
   end

   assign window = win_q;
   assign filled = (fill_q == FILL_MAX);

endmodule

// File: rtl/cpc_coef_bank.sv
module cpc_coef_bank #(
   parameter int unsigned WIN_BITS    = 256,
   parameter int unsigned WORD_W      = 32,
   parameter bit          STAGED_COEF = 1'b1,
   parameter int unsigned ADDR_W      = $clog2(WIN_BITS / WORD_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [WORD_W-1:0]    wr_data,
   input  logic                 commit,
   output logic [WIN_BITS-1:0]  coef
);

   localparam int unsigned WORDS = WIN_BITS / WORD_W;

   logic [WIN_BITS-1:0] active_q;

   generate
      if (STAGED_COEF) begin : g_staged
         logic [WIN_BITS-1:0] stage_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stage_q <= '0;
            end else if (wr_en) begin
               for (int w = 0; w < WORDS; w++) begin
                  if (wr_addr == ADDR_W'(w)) begin
                     stage_q[w*WORD_W +: WORD_W] <= wr_data;
                  end
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               active_q <= '0;
            end else if (commit) begin
               active_q <= stage_q;
            end
         end
      end else begin : g_direct
         logic unused_commit;
         assign unused_commit = commit;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               active_q <= '0;
            end else if (wr_en) begin
               for (int w = 0; w < WORDS; w++) begin
                  if (wr_addr == ADDR_W'(w)) begin
                     active_q[w*WORD_W +: WORD_W] <= wr_data;
                  end
               end
            end
         end
      end
   endgenerate

   assign coef = active_q;

endmodule

// File: rtl/cpc_pe.sv
module cpc_pe (
   input  logic [1:0] win_bits,
   input  logic [1:0] coef_bits,
   output logic [1:0] score
);

   logic [1:0] agree;

   assign agree = ~(win_bits ^ coef_bits);
   assign score = {1'b0, agree[1]} + {1'b0, agree[0]};

endmodule

// File: rtl/cpc_match_tree.sv
module cpc_match_tree #(
   parameter int unsigned WIN_BITS = 256
) (
   input  logic [WIN_BITS-1:0]               window,
   input  logic [WIN_BITS-1:0]               coef,
   output logic [$clog2(WIN_BITS+1)-1:0]     total
);

   localparam int unsigned NUM_PE = WIN_BITS / 2;
   localparam int unsigned LEVELS = $clog2(NUM_PE);

   logic [1:0] pe_score [NUM_PE];

   generate
      for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
         cpc_pe i_pe (
            .win_bits (window[2*p +: 2]),
            .coef_bits(coef[2*p +: 2]),
            .score    (pe_score[p])
         );
      end

      for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
         localparam int unsigned NODES = NUM_PE >> l;
         localparam int unsigned NW    = l + 2;
         logic [NW-1:0] node [NODES];

         if (l == 0) begin : g_leaf
            for (genvar j = 0; j < NODES; j++) begin : g_n
               assign node[j] = pe_score[j];
            end
         end else begin : g_add
            for (genvar j = 0; j < NODES; j++) begin : g_n
               assign node[j] = {1'b0, g_lvl[l-1].node[2*j]}
                              + {1'b0, g_lvl[l-1].node[2*j+1]};
            end
         end
      end
   endgenerate

   assign total = g_lvl[LEVELS].node[0];

endmodule

// File: rtl/cpc_peak_detect.sv
module cpc_peak_detect #(
   parameter int unsigned CNT_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  count_in,
   input  logic              filled,
   input  logic [CNT_W-1:0]  thresh,
   output logic [CNT_W-1:0]  match_count,
   output logic              detect
);

   logic             above_now;
   logic             above_q;
   logic [CNT_W-1:0] count_q;
   logic             detect_q;

   assign above_now = filled && (count_in > thresh);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q  <= '0;
         above_q  <= 1'b0;
         detect_q <= 1'b0;
      end else begin
         count_q  <= count_in;
         above_q  <= above_now;
         detect_q <= above_now && !above_q;
      end
   end

   assign match_count = count_q;
   assign detect      = detect_q;

endmodule

// File: rtl/sign_preamble_correlator.sv
module sign_preamble_correlator #(
   parameter int unsigned SAMPLE_W    = 12,
   parameter int unsigned WIN_SAMPLES = 128,
   parameter int unsigned COEF_WORD_W = 32,
   parameter bit          STAGED_COEF = 1'b1
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        smp_valid,
   input  logic [SAMPLE_W-1:0]                         smp_i,
   input  logic [SAMPLE_W-1:0]                         smp_q,
   input  logic                                        coef_wr_en,
   input  logic [$clog2(2*WIN_SAMPLES/COEF_WORD_W)-1:0] coef_wr_addr,
   input  logic [COEF_WORD_W-1:0]                      coef_wr_data,
   input  logic                                        coef_commit,
   input  logic [$clog2(2*WIN_SAMPLES+1)-1:0]          thresh,
   output logic [$clog2(2*WIN_SAMPLES+1)-1:0]          match_count,
   output logic                                        detect
);

   localparam int unsigned WIN_BITS   = 2 * WIN_SAMPLES;
   localparam int unsigned CNT_W      = $clog2(WIN_BITS + 1);
   localparam int unsigned COEF_WORDS = WIN_BITS / COEF_WORD_W;
   localparam int unsigned ADDR_W     = $clog2(COEF_WORDS);

   generate
      if (SAMPLE_W < 2) begin : g_bad_sample_w
         $error("SAMPLE_W must be at least 2");
      end
      if (WIN_SAMPLES < 2 || (WIN_SAMPLES & (WIN_SAMPLES - 1)) != 0) begin : g_bad_win
         $error("WIN_SAMPLES must be a power of two, at least 2");
      end
      if (COEF_WORD_W == 0 || (WIN_BITS % COEF_WORD_W) != 0 || COEF_WORDS < 2) begin : g_bad_word
         $error("COEF_WORD_W must split the window into at least two whole words");
      end
   endgenerate

   logic [WIN_BITS-1:0] window;
   logic [WIN_BITS-1:0] coef;
   logic                filled;
   logic [CNT_W-1:0]    raw_count;
   logic                unused_mag;

   assign unused_mag = ^{smp_i[SAMPLE_W-2:0], smp_q[SAMPLE_W-2:0]};

   cpc_window #(
      .SAMPLE_W   (SAMPLE_W),
      .WIN_SAMPLES(WIN_SAMPLES)
   ) i_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_valid(smp_valid),
      .i_sign   (smp_i[SAMPLE_W-1]),
      .q_sign   (smp_q[SAMPLE_W-1]),
      .window   (window),
      .filled   (filled)
   );

   cpc_coef_bank #(
      .WIN_BITS   (WIN_BITS),
      .WORD_W     (COEF_WORD_W),
      .STAGED_COEF(STAGED_COEF),
      .ADDR_W     (ADDR_W)
   ) i_coef_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (coef_wr_en),
      .wr_addr(coef_wr_addr),
      .wr_data(coef_wr_data),
      .commit (coef_commit),
      .coef   (coef)
   );

   cpc_match_tree #(
      .WIN_BITS(WIN_BITS)
   ) i_match_tree (
      .window(window),
      .coef  (coef),
      .total (raw_count)
   );

   cpc_peak_detect #(
      .CNT_W(CNT_W)
   ) i_peak_detect (
      .clk        (clk),
      .rst_n      (rst_n),
      .count_in   (raw_count),
      .filled     (filled),
      .thresh     (thresh),
      .match_count(match_count),
      .detect     (detect)
   );

endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
   parameter int unsigned WIN_SAMPLES = 128,
   parameter bit          STAGED_COEF = 1'b1
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               smp_valid,
   input logic                               coef_wr_en,
   input logic                               coef_commit,
   input logic [$clog2(2*WIN_SAMPLES+1)-1:0] thresh,
   input logic [$clog2(2*WIN_SAMPLES+1)-1:0] match_count,
   input logic                               detect
);

   localparam int unsigned WIN_BITS = 2 * WIN_SAMPLES;
   localparam int unsigned SEEN_W   = $clog2(WIN_SAMPLES + 1);
   localparam int unsigned CNT_W    = $clog2(WIN_BITS + 1);

   logic [SEEN_W-1:0] seen_q;
   logic [1:0]        age_q;
   logic              quiet;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= '0;
         age_q  <= '0;
      end else begin
         if (smp_valid && seen_q != SEEN_W'(WIN_SAMPLES)) begin
            seen_q <= seen_q + 1'b1;
         end
         if (age_q != 2'd3) begin
            age_q <= age_q + 1'b1;
         end
      end
   end

   generate
      if (STAGED_COEF) begin : g_quiet_staged
         logic unused_wr;
         assign unused_wr = coef_wr_en;
         assign quiet = !smp_valid && !coef_commit;
      end else begin : g_quiet_direct
         assign quiet = !smp_valid && !coef_commit && !coef_wr_en;
      end
   endgenerate

   assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      match_count <= CNT_W'(WIN_BITS));

   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      detect |=> !detect);

   assert_fill_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      detect |-> (seen_q == SEEN_W'(WIN_SAMPLES)));

   assert_strict_threshold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      detect |-> (match_count > $past(thresh)));

   // R5 and R10: staging writes and threshold changes never move the count
   assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && $past(quiet, 2)) |-> $stable(match_count));

endmodule

bind sign_preamble_correlator cpc_checker #(
   .WIN_SAMPLES(WIN_SAMPLES),
   .STAGED_COEF(STAGED_COEF)
) i_cpc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_valid  (smp_valid),
   .coef_wr_en (coef_wr_en),
   .coef_commit(coef_commit),
   .thresh     (thresh),
   .match_count(match_count),
   .detect     (detect)
);

// File: tb/test_sign_preamble_correlator.sv
module test_sign_preamble_correlator;

   localparam int NS    = 128;
   localparam int NB    = 256;
   localparam int WORDS = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               smp_valid = 1'b0;
   logic signed [11:0] smp_i = '0;
   logic signed [11:0] smp_q = '0;
   logic               coef_wr_en = 1'b0;
   logic [2:0]         coef_wr_addr = '0;
   logic [31:0]        coef_wr_data = '0;
   logic               coef_commit = 1'b0;
   logic [8:0]         thresh = '0;
   logic [8:0]         match_count;
   logic               detect;

   int n_checks = 0;
   int n_fails  = 0;
   int det_seen = 0;
   int peak_cnt = 0;

   logic [NB-1:0] m_win   = '0;
   logic [NB-1:0] m_coef  = '0;
   logic [31:0]   m_stage [WORDS];
   int            m_fill  = 0;
   bit            m_above = 1'b0;
   logic [NB-1:0] pat;

   always #4 clk = ~clk;

   sign_preamble_correlator i_sign_preamble_correlator (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_valid   (smp_valid),
      .smp_i       (smp_i),
      .smp_q       (smp_q),
      .coef_wr_en  (coef_wr_en),
      .coef_wr_addr(coef_wr_addr),
      .coef_wr_data(coef_wr_data),
      .coef_commit (coef_commit),
      .thresh      (thresh),
      .match_count (match_count),
      .detect      (detect)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int agree_count(input logic [NB-1:0] a, input logic [NB-1:0] b);
      int s = 0;
      for (int k = 0; k < NB; k++) begin
         if (a[k] == b[k]) s++;
      end
      return s;
   endfunction

   function automatic logic signed [11:0] mk(input bit neg, input int k);
      int mag = 1 + ((k * 173 + 29) % 2000);
      return neg ? 12'(-mag) : 12'(mag);
   endfunction

   // one clock: apply inputs, predict outputs for this edge, then compare
   task automatic cycle(input bit v, input logic signed [11:0] si, input logic signed [11:0] sq,
                        input bit we, input int wa, input logic [31:0] wd,
                        input bit cm, input string tag);
      int  exp_cnt;
      bit  exp_above;
      bit  exp_det;
      smp_valid    = v;
      smp_i        = si;
      smp_q        = sq;
      coef_wr_en   = we;
      coef_wr_addr = 3'(wa);
      coef_wr_data = wd;
      coef_commit  = cm;
      exp_cnt   = agree_count(m_win, m_coef);
      exp_above = (m_fill >= NS) && (exp_cnt > int'(thresh));
      exp_det   = exp_above && !m_above;
      m_above   = exp_above;
      if (v) begin
         m_win = {m_win[NB-3:0], si[11], sq[11]};
         if (m_fill < NS) m_fill++;
      end
      if (cm) begin
         for (int w = 0; w < WORDS; w++) m_coef[w*32 +: 32] = m_stage[w];
      end
      if (we) m_stage[wa] = wd;
      @(negedge clk);
      smp_valid   = 1'b0;
      coef_wr_en  = 1'b0;
      coef_commit = 1'b0;
      check(match_count == 9'(exp_cnt), {tag, " match_count"}, int'(match_count), exp_cnt);
      check(detect == exp_det, {tag, " detect"}, int'(detect), int'(exp_det));
      if (detect) det_seen++;
      if (int'(match_count) > peak_cnt) peak_cnt = int'(match_count);
   endtask

   task automatic idle(input string tag);
      cycle(1'b0, 12'sd0, 12'sd0, 1'b0, 0, 32'h0, 1'b0, tag);
   endtask

   task automatic noise(input int k, input string tag);
      cycle(1'b1, mk(((k * 7 + 3) % 5) < 2, k), mk(((k * 11 + 1) % 3) == 0, k + 5),
            1'b0, 0, 32'h0, 1'b0, tag);
   endtask

   task automatic preamble(input string tag);
      for (int s = 0; s < NS; s++) begin
         cycle(1'b1, mk(pat[2*(NS-1-s)+1], s), mk(pat[2*(NS-1-s)], s + 9),
               1'b0, 0, 32'h0, 1'b0, tag);
      end
   endtask

   task automatic load(input logic [NB-1:0] p, input string tag);
      for (int w = 0; w < WORDS; w++) begin
         cycle(1'b0, 12'sd0, 12'sd0, 1'b1, w, p[w*32 +: 32], 1'b0, tag);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      logic [15:0] lf = 16'hACE1;
      for (int w = 0; w < WORDS; w++) m_stage[w] = '0;
      for (int b = 0; b < NB; b++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         pat[b] = lf[0];
      end

      // R9: reset state
      repeat (3) @(negedge clk);
      check(match_count == 9'd0, "R9 reset match_count", int'(match_count), 0);
      check(detect == 1'b0, "R9 reset detect", int'(detect), 0);
      rst_n = 1'b1;
      idle("R9");
      check(match_count == 9'd256, "R9 first count after reset", int'(match_count), 256);

      // R10: hold while idle, also under threshold changes
      thresh = 9'd100;
      idle("R10");
      thresh = 9'd3;
      idle("R10");
      check(match_count == 9'd256, "R10 held count", int'(match_count), 256);

      // R5: staging writes do not reach the count before commit
      load(pat, "R5 staging");
      idle("R5 staging");
      check(match_count == 9'd256, "R5 count before commit", int'(match_count), 256);
      cycle(1'b0, 12'sd0, 12'sd0, 1'b0, 0, 32'h0, 1'b1, "R5 commit");
      idle("R5 commit");
      check(int'(match_count) == agree_count('0, pat), "R5 count after commit",
            int'(match_count), agree_count('0, pat));

      // R8: zero threshold, detect only once the window has filled
      thresh = 9'd0;
      det_seen = 0;
      for (int k = 0; k < NS - 1; k++) noise(k, "R8 filling");
      check(det_seen == 0, "R8 no detect before fill", det_seen, 0);
      for (int k = 0; k < 6; k++) noise(NS + k, "R8 filled");
      check(det_seen == 1, "R8 single detect at fill", det_seen, 1);

      // R2/R3: aligned preamble yields full score, R7 one pulse while sustained
      thresh = 9'd240;
      for (int k = 0; k < 40; k++) noise(300 + k, "R3 noise");
      det_seen = 0;
      peak_cnt = 0;
      preamble("R2 preamble");
      for (int k = 0; k < 6; k++) idle("R7 sustained");
      check(match_count == 9'd256, "R3 aligned full match", int'(match_count), 256);
      check(peak_cnt == 256, "R4 peak reaches maximum", peak_cnt, 256);
      check(det_seen == 1, "R7 one detect for sustained peak", det_seen, 1);

      // R6: strict compare at the boundary
      det_seen = 0;
      thresh = 9'd256;
      for (int k = 0; k < 3; k++) idle("R6 equal");
      check(det_seen == 0, "R6 no detect at equal", det_seen, 0);
      thresh = 9'd255;
      idle("R6 one below");
      idle("R6 one below");
      check(det_seen == 1, "R6 detect when above", det_seen, 1);

      // R5: atomic commit of inverted preamble, full to zero in one step
      load(~pat, "R5 invert staging");
      check(match_count == 9'd256, "R5 unchanged by staging", int'(match_count), 256);
      cycle(1'b0, 12'sd0, 12'sd0, 1'b0, 0, 32'h0, 1'b1, "R5 invert commit");
      idle("R5 invert commit");
      check(match_count == 9'd0, "R5 atomic drop to zero", int'(match_count), 0);

      // R1: extreme sample values, only the sign bit counts
      thresh = 9'd200;
      cycle(1'b1, 12'sd0, -12'sd1, 1'b0, 0, 32'h0, 1'b0, "R1 extremes");
      cycle(1'b1, 12'sd2047, -12'sd2048, 1'b0, 0, 32'h0, 1'b0, "R1 extremes");
      cycle(1'b1, -12'sd2048, 12'sd1, 1'b0, 0, 32'h0, 1'b0, "R1 extremes");
      cycle(1'b1, -12'sd1, 12'sd0, 1'b0, 0, 32'h0, 1'b0, "R1 extremes");
      idle("R1 extremes");
      check(int'(match_count) == agree_count(m_win, m_coef), "R1 sign-only count",
            int'(match_count), agree_count(m_win, m_coef));

      // R7: re-arm after falling, second preamble gives a second pulse
      load(pat, "R7 reload");
      cycle(1'b0, 12'sd0, 12'sd0, 1'b0, 0, 32'h0, 1'b1, "R7 reload commit");
      thresh = 9'd240;
      for (int k = 0; k < 30; k++) noise(700 + k, "R7 noise");
      det_seen = 0;
      preamble("R7 second preamble");
      idle("R7 second preamble");
      idle("R7 second preamble");
      check(det_seen == 1, "R7 re-armed detect", det_seen, 1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule